// File: doc/BRIEF.md
# Multi-Channel Transfer Priority Arbiter

This block is the arbitration and per-channel control core of an eight-channel transfer engine. Each channel is programmed with a priority level, a circular-mode switch, separate element sizes for its read and write sides, two start addresses and an item count. Once enabled, a channel asks for service either while its hardware request line is high, or after a one-cycle software start pulse. The software start lasts until the block reaches its end.

The arbiter looks at the channels only while no command is in flight. It picks one requesting channel: first by the programmed level, then by the lowest channel number. For that channel it presents one transfer command to a simple memory port, with a valid/ready handshake and an error response. When the transfer finishes, the channel's addresses step forward by their own element sizes and its remaining count drops by one. The channel raises its half-done, done or fault flags, which are merged into one interrupt per channel. In circular mode the count and addresses are reloaded at the end of a block. A channel whose current address does not fit its element size is faulted and switched off without any command. Arbitration runs again after every single transfer.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset every channel is disabled, all flags and interrupts are 0, and `xfer_valid` is 0. Request inputs have no effect until a channel is enabled through the configuration port.
- R2: When several enabled channels request service, the channel with the numerically highest priority gets the next command. The encoding is 3 = very high, 2 = high, 1 = medium, 0 = low.
- R3: Among requesting channels of equal priority, the lowest channel number wins.
- R4: An enabled channel requests while its `hw_req` bit is 1. A `sw_start` pulse makes it request until its block completes, a configuration write or a fault. A disabled channel ignores both inputs.
- R5: A command holds `xfer_valid`, channel, addresses and sizes stable until `xfer_ready`. Only one command is outstanding at a time. After each transfer the source and destination addresses each advance by their own size. The size code is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes.
- R6: A count of 0 means 2^CNT_W transfers.
- R7: The half flag sets when the remaining count falls to floor(total/2). The done flag sets when it reaches 0, and a non-circular channel is then disabled.
- R8: In circular mode, reaching a count of 0 reloads the count and both start addresses, and the channel stays enabled.
- R9: If an arbitration winner has a size code of 3, or an address not a multiple of its size, it gets the fault flag and is disabled, and no command is issued.
- R10: A transfer answered with `xfer_err` sets the fault flag and disables the channel, with no count or address update.
- R11: `irq[i]` is the OR of channel i's half, done and fault flags. A `flag_clr[i]` pulse clears all three flags of that channel.
- R12: Arbitration is repeated after every transfer. A higher-priority request that appears during another channel's block takes the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req | input | N_CH | Hardware request level per channel |
| sw_start | input | N_CH | Software start pulse per channel |
| flag_clr | input | N_CH | Clear all flags of a channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel written |
| cfg_en | input | 1 | Enable for the written channel |
| cfg_prio | input | 2 | Priority level |
| cfg_circ | input | 1 | Circular mode |
| cfg_src_size | input | 2 | Source element size code |
| cfg_dst_size | input | 2 | Destination element size code |
| cfg_src_addr | input | ADDR_W | Source start address |
| cfg_dst_addr | input | ADDR_W | Destination start address |
| cfg_count | input | CNT_W | Item count (0 = 2^CNT_W) |
| xfer_valid | output | 1 | Command valid |
| xfer_ready | input | 1 | Memory port accepts and completes the command |
| xfer_err | input | 1 | Error response, qualified by ready |
| xfer_ch | output | CH_W | Channel served |
| xfer_src_addr | output | ADDR_W | Read address |
| xfer_dst_addr | output | ADDR_W | Write address |
| xfer_src_size | output | 2 | Read size code |
| xfer_dst_size | output | 2 | Write size code |
| ht_flag | output | N_CH | Half-done flags |
| tc_flag | output | N_CH | Block-done flags |
| te_flag | output | N_CH | Fault flags |
| irq | output | N_CH | Per-channel merged interrupt |

## Verification
The hardest situation to reach from the ports is a misaligned channel winning arbitration while aligned channels also request. It must fault and drop out, and the next best channel must still be served, with no stray command in between. The random phase programs some channels with odd addresses or the reserved size code and raises several requests at once. The bench's model repeats the fault-then-retry sequence to predict which channel is finally served. A count-zero block run to the very end, and a priority raised partway through a block, are driven as directed cases.

// File: rtl/dmarb_pkg.sv
// Shared types and helpers for the transfer priority arbiter.
// Assumes byte addressing; element sizes are 1, 2 or 4 bytes.
package dmarb_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xsize_e;

    // True when the low address bits suit the element size.
    function automatic logic fits_size(input logic [1:0] lo, input xsize_e sz);
        case (sz)
            SZ_BYTE: return 1'b1;
            SZ_HALF: return ~lo[0];
            SZ_WORD: return (lo == 2'b00);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dmarb_chan.sv
// One channel: holds configuration, current addresses, remaining count
// and status flags. Assumes done_i and fault_i are never raised together
// (the top grants or completes, never both for one channel in one cycle).
module dmarb_chan
    import dmarb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic              cfg_en_i,
    input  logic [1:0]        cfg_prio_i,
    input  logic              cfg_circ_i,
    input  logic [1:0]        cfg_ssz_i,
    input  logic [1:0]        cfg_dsz_i,
    input  logic [ADDR_W-1:0] cfg_src_i,
    input  logic [ADDR_W-1:0] cfg_dst_i,
    input  logic [CNT_W-1:0]  cfg_cnt_i,
    input  logic              hw_req_i,
    input  logic              sw_start_i,
    input  logic              flag_clr_i,
    input  logic              fault_i,
    input  logic              done_i,
    input  logic              err_i,
    output logic              req_o,
    output logic [1:0]        prio_o,
    output logic              bad_o,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [1:0]        ssz_o,
    output logic [1:0]        dsz_o,
    output logic              ht_o,
    output logic              tc_o,
    output logic              te_o,
    output logic              irq_o
);
    localparam int CTW = CNT_W + 1;

    logic              en_q, swrun_q, circ_q;
    logic [1:0]        prio_q;
    xsize_e            ssz_q, dsz_q;
    logic [ADDR_W-1:0] sbase_q, dbase_q, scur_q, dcur_q;
    logic [CTW-1:0]    total_q, rem_q;
    logic              ht_q, tc_q, te_q;

    logic [CTW-1:0]    cfg_total, rem_dec;
    logic [ADDR_W-1:0] sstep, dstep;
    logic              ok_done, reach_half, reach_end;

    // Decode the programmed count; zero stands for the full range.
    always_comb begin
        cfg_total = (cfg_cnt_i == '0) ? (CTW'(1) << CNT_W) : {1'b0, cfg_cnt_i};
    end

    // Byte steps of each side and end-of-transfer conditions.
    always_comb begin
        sstep      = ADDR_W'(1) << ssz_q;
        dstep      = ADDR_W'(1) << dsz_q;
        rem_dec    = rem_q - CTW'(1);
        ok_done    = done_i & ~err_i;
        reach_half = ok_done & (rem_dec == (total_q >> 1));
        reach_end  = ok_done & (rem_dec == '0);
    end

    // Configuration load, progress on completion, faults and software start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            swrun_q <= 1'b0;
            circ_q  <= 1'b0;
            prio_q  <= 2'd0;
            ssz_q   <= SZ_BYTE;
            dsz_q   <= SZ_BYTE;
            sbase_q <= '0;
            dbase_q <= '0;
            scur_q  <= '0;
            dcur_q  <= '0;
            total_q <= '0;
            rem_q   <= '0;
        end else if (cfg_we_i) begin
            en_q    <= cfg_en_i;
            swrun_q <= 1'b0;
            circ_q  <= cfg_circ_i;
            prio_q  <= cfg_prio_i;
            ssz_q   <= xsize_e'(cfg_ssz_i);
            dsz_q   <= xsize_e'(cfg_dsz_i);
            sbase_q <= cfg_src_i;
            dbase_q <= cfg_dst_i;
            scur_q  <= cfg_src_i;
            dcur_q  <= cfg_dst_i;
            total_q <= cfg_total;
            rem_q   <= cfg_total;
        end else if (fault_i || (done_i && err_i)) begin
            en_q    <= 1'b0;
            swrun_q <= 1'b0;
        end else if (ok_done) begin
            if (reach_end) begin
                swrun_q <= 1'b0;
                if (circ_q) begin
                    rem_q  <= total_q;
                    scur_q <= sbase_q;
                    dcur_q <= dbase_q;
                end else begin
                    en_q   <= 1'b0;
                    rem_q  <= rem_dec;
                    scur_q <= scur_q + sstep;
                    dcur_q <= dcur_q + dstep;
                end
            end else begin
                rem_q  <= rem_dec;
                scur_q <= scur_q + sstep;
                dcur_q <= dcur_q + dstep;
            end
        end else if (sw_start_i && en_q) begin
            swrun_q <= 1'b1;
        end
    end

    // Sticky flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ht_q <= 1'b0;
            tc_q <= 1'b0;
            te_q <= 1'b0;
        end else begin
            ht_q <= reach_half | (ht_q & ~flag_clr_i);
            tc_q <= reach_end  | (tc_q & ~flag_clr_i);
            te_q <= fault_i | (done_i & err_i) | (te_q & ~flag_clr_i);
        end
    end

    // Outward view of the channel.
    always_comb begin
        req_o  = en_q & (hw_req_i | swrun_q);
        prio_o = prio_q;
        bad_o  = ~fits_size(scur_q[1:0], ssz_q) | ~fits_size(dcur_q[1:0], dsz_q);
        src_o  = scur_q;
        dst_o  = dcur_q;
        ssz_o  = ssz_q;
        dsz_o  = dsz_q;
        ht_o   = ht_q;
        tc_o   = tc_q;
        te_o   = te_q;
        irq_o  = ht_q | tc_q | te_q;
    end

endmodule

// File: rtl/dmarb_pick.sv
// Two-level winner selection: highest priority level first, then the
// lowest channel index among equals. Purely combinational.
module dmarb_pick #(
    parameter int N_CH = 8,
    parameter int CH_W = $clog2(N_CH)
) (
    input  logic [N_CH-1:0]       req_i,
    input  logic [N_CH-1:0][1:0]  prio_i,
    output logic                  any_o,
    output logic [CH_W-1:0]       idx_o
);
    logic [1:0] best;

    // Scan upward; only a strictly higher level displaces the held winner.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        best  = 2'd0;
        for (int i = 0; i < N_CH; i++) begin
            if (req_i[i] && (!any_o || prio_i[i] > best)) begin
                any_o = 1'b1;
                idx_o = CH_W'(i);
                best  = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/dma_prio_arbiter.sv
// Arbitration and per-channel control of an N_CH-channel transfer engine.
// Arbitrates only while no command is outstanding, so every transfer is
// followed by a fresh decision. Assumes the memory port completes a
// command in the cycle it asserts xfer_ready.
module dma_prio_arbiter #(
    parameter int N_CH   = 8,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int CH_W   = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   hw_req,
    input  logic [N_CH-1:0]   sw_start,
    input  logic [N_CH-1:0]   flag_clr,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic              cfg_en,
    input  logic [1:0]        cfg_prio,
    input  logic              cfg_circ,
    input  logic [1:0]        cfg_src_size,
    input  logic [1:0]        cfg_dst_size,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    input  logic              xfer_err,
    output logic [CH_W-1:0]   xfer_ch,
    output logic [ADDR_W-1:0] xfer_src_addr,
    output logic [ADDR_W-1:0] xfer_dst_addr,
    output logic [1:0]        xfer_src_size,
    output logic [1:0]        xfer_dst_size,
    output logic [N_CH-1:0]   ht_flag,
    output logic [N_CH-1:0]   tc_flag,
    output logic [N_CH-1:0]   te_flag,
    output logic [N_CH-1:0]   irq
);
    logic [N_CH-1:0]       req_vec, bad_vec, done_vec, fault_vec;
    logic [N_CH-1:0][1:0]  prio_vec, ssz_vec, dsz_vec;
    logic [ADDR_W-1:0]     src_arr [N_CH];
    logic [ADDR_W-1:0]     dst_arr [N_CH];

    logic                  win_any;
    logic [CH_W-1:0]       win_idx;
    logic                  arb_slot, issue;

    logic                  cmd_valid_q;
    logic [CH_W-1:0]       cmd_ch_q;
    logic [ADDR_W-1:0]     cmd_src_q, cmd_dst_q;
    logic [1:0]            cmd_ssz_q, cmd_dsz_q;

    // One control instance per channel.
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        dmarb_chan #(
            .ADDR_W(ADDR_W),
            .CNT_W (CNT_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we_i   (cfg_we && (cfg_ch == CH_W'(g))),
            .cfg_en_i   (cfg_en),
            .cfg_prio_i (cfg_prio),
            .cfg_circ_i (cfg_circ),
            .cfg_ssz_i  (cfg_src_size),
            .cfg_dsz_i  (cfg_dst_size),
            .cfg_src_i  (cfg_src_addr),
            .cfg_dst_i  (cfg_dst_addr),
            .cfg_cnt_i  (cfg_count),
            .hw_req_i   (hw_req[g]),
            .sw_start_i (sw_start[g]),
            .flag_clr_i (flag_clr[g]),
            .fault_i    (fault_vec[g]),
            .done_i     (done_vec[g]),
            .err_i      (xfer_err),
            .req_o      (req_vec[g]),
            .prio_o     (prio_vec[g]),
            .bad_o      (bad_vec[g]),
            .src_o      (src_arr[g]),
            .dst_o      (dst_arr[g]),
            .ssz_o      (ssz_vec[g]),
            .dsz_o      (dsz_vec[g]),
            .ht_o       (ht_flag[g]),
            .tc_o       (tc_flag[g]),
            .te_o       (te_flag[g]),
            .irq_o      (irq[g])
        );
    end

    dmarb_pick #(
        .N_CH(N_CH),
        .CH_W(CH_W)
    ) u_pick (
        .req_i  (req_vec),
        .prio_i (prio_vec),
        .any_o  (win_any),
        .idx_o  (win_idx)
    );

    // Slot decision: fault a misaligned winner, otherwise issue it.
    always_comb begin
        arb_slot  = ~cmd_valid_q & win_any;
        issue     = arb_slot & ~bad_vec[win_idx];
        fault_vec = (arb_slot && bad_vec[win_idx]) ? (N_CH'(1) << win_idx) : '0;
        done_vec  = (cmd_valid_q && xfer_ready) ? (N_CH'(1) << cmd_ch_q) : '0;
    end

    // Command register toward the memory port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid_q <= 1'b0;
            cmd_ch_q    <= '0;
            cmd_src_q   <= '0;
            cmd_dst_q   <= '0;
            cmd_ssz_q   <= 2'd0;
            cmd_dsz_q   <= 2'd0;
        end else if (issue) begin
            cmd_valid_q <= 1'b1;
            cmd_ch_q    <= win_idx;
            cmd_src_q   <= src_arr[win_idx];
            cmd_dst_q   <= dst_arr[win_idx];
            cmd_ssz_q   <= ssz_vec[win_idx];
            cmd_dsz_q   <= dsz_vec[win_idx];
        end else if (cmd_valid_q && xfer_ready) begin
            cmd_valid_q <= 1'b0;
        end
    end

    // Drive the memory port from the command register.
    always_comb begin
        xfer_valid    = cmd_valid_q;
        xfer_ch       = cmd_ch_q;
        xfer_src_addr = cmd_src_q;
        xfer_dst_addr = cmd_dst_q;
        xfer_src_size = cmd_ssz_q;
        xfer_dst_size = cmd_dsz_q;
    end

endmodule

// File: rtl/dmarb_chk.sv
// Property checker for dma_prio_arbiter, attached by bind below.
module dmarb_chk
    import dmarb_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int ADDR_W = 32,
    parameter int CH_W   = $clog2(N_CH)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 xfer_valid,
    input logic                 xfer_ready,
    input logic                 xfer_err,
    input logic [CH_W-1:0]      xfer_ch,
    input logic [ADDR_W-1:0]    xfer_src_addr,
    input logic [ADDR_W-1:0]    xfer_dst_addr,
    input logic [1:0]           xfer_src_size,
    input logic [1:0]           xfer_dst_size,
    input logic [N_CH-1:0]      req_vec,
    input logic [N_CH-1:0][1:0] prio_vec,
    input logic [N_CH-1:0]      done_vec,
    input logic [N_CH-1:0]      fault_vec,
    input logic [N_CH-1:0]      tc_flag,
    input logic [N_CH-1:0]      te_flag
);
    logic [N_CH-1:0]       req_q;
    logic [N_CH-1:0][1:0]  prio_q;
    logic                  valid_q;
    logic                  better;

    // Remember the request picture the last decision was based on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= '0;
            prio_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            req_q   <= req_vec;
            prio_q  <= prio_vec;
            valid_q <= xfer_valid;
        end
    end

    // Was some other requester ahead of the one just granted?
    always_comb begin
        better = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            if (req_q[i] && ((prio_q[i] > prio_q[xfer_ch]) ||
                (prio_q[i] == prio_q[xfer_ch] && i < int'(xfer_ch))))
                better = 1'b1;
        end
    end

    // R2 and R3: a new grant never passes over a better requester.
    a_r2_best_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !valid_q) |-> !better);

    // R5: a stalled command keeps its content.
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_ch) &&
        $stable(xfer_src_addr) && $stable(xfer_dst_addr)));

    // R9: every issued command is aligned on both sides.
    a_r9_aligned_only: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (fits_size(xfer_src_addr[1:0], xsize_e'(xfer_src_size)) &&
                        fits_size(xfer_dst_addr[1:0], xsize_e'(xfer_dst_size))));

    // R10: a fault flag only rises after a grant fault or an error response.
    a_r10_te_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ((te_flag & ~$past(te_flag)) & ~$past(fault_vec | (done_vec & {N_CH{xfer_err}}))) == '0);

    // R7: a done flag only rises after a completed transfer.
    a_r7_tc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ((tc_flag & ~$past(tc_flag)) & ~$past(done_vec)) == '0);

endmodule

bind dma_prio_arbiter dmarb_chk #(
    .N_CH  (N_CH),
    .ADDR_W(ADDR_W),
    .CH_W  (CH_W)
) u_dmarb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_valid   (xfer_valid),
    .xfer_ready   (xfer_ready),
    .xfer_err     (xfer_err),
    .xfer_ch      (xfer_ch),
    .xfer_src_addr(xfer_src_addr),
    .xfer_dst_addr(xfer_dst_addr),
    .xfer_src_size(xfer_src_size),
    .xfer_dst_size(xfer_dst_size),
    .req_vec      (req_vec),
    .prio_vec     (prio_vec),
    .done_vec     (done_vec),
    .fault_vec    (fault_vec),
    .tc_flag      (tc_flag),
    .te_flag      (te_flag)
);

// File: tb/dma_prio_arbiter_test.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared with a channel model kept in bench variables.
module dma_prio_arbiter_test;
    localparam int N  = 8;
    localparam int AW = 32;
    localparam int CW = 8;
    localparam int HW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  hw_req = '0, sw_start = '0, flag_clr = '0;
    logic          cfg_we = 1'b0, cfg_en = 1'b0, cfg_circ = 1'b0;
    logic [HW-1:0] cfg_ch = '0;
    logic [1:0]    cfg_prio = '0, cfg_src_size = '0, cfg_dst_size = '0;
    logic [AW-1:0] cfg_src_addr = '0, cfg_dst_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          xfer_ready = 1'b0, xfer_err = 1'b0;
    logic          xfer_valid;
    logic [HW-1:0] xfer_ch;
    logic [AW-1:0] xfer_src_addr, xfer_dst_addr;
    logic [1:0]    xfer_src_size, xfer_dst_size;
    logic [N-1:0]  ht_flag, tc_flag, te_flag, irq;

    dma_prio_arbiter #(.N_CH(N), .ADDR_W(AW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_start(sw_start),
        .flag_clr(flag_clr), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_en(cfg_en),
        .cfg_prio(cfg_prio), .cfg_circ(cfg_circ), .cfg_src_size(cfg_src_size),
        .cfg_dst_size(cfg_dst_size), .cfg_src_addr(cfg_src_addr),
        .cfg_dst_addr(cfg_dst_addr), .cfg_count(cfg_count),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_err(xfer_err),
        .xfer_ch(xfer_ch), .xfer_src_addr(xfer_src_addr),
        .xfer_dst_addr(xfer_dst_addr), .xfer_src_size(xfer_src_size),
        .xfer_dst_size(xfer_dst_size), .ht_flag(ht_flag), .tc_flag(tc_flag),
        .te_flag(te_flag), .irq(irq)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    // Channel model.
    bit          m_en[N], m_sw[N], m_circ[N], m_ht[N], m_tc[N], m_te[N];
    int          m_prio[N], m_ssz[N], m_dsz[N], m_tot[N], m_rem[N];
    logic [31:0] m_sb[N], m_db[N], m_sc[N], m_dc[N];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit al(input logic [31:0] a, input int s);
        case (s)
            0: return 1'b1;
            1: return ~a[0];
            2: return a[1:0] == 2'b00;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit m_bad(input int c);
        return !al(m_sc[c], m_ssz[c]) || !al(m_dc[c], m_dsz[c]);
    endfunction

    function automatic int m_pick();
        int w = -1;
        for (int i = 0; i < N; i++)
            if (m_en[i] && (hw_req[i] || m_sw[i]) && (w < 0 || m_prio[i] > m_prio[w]))
                w = i;
        return w;
    endfunction

    function automatic logic [N-1:0] vec(input int k);
        logic [N-1:0] v = '0;
        for (int i = 0; i < N; i++)
            v[i] = (k == 0) ? m_ht[i] : (k == 1) ? m_tc[i] : m_te[i];
        return v;
    endfunction

    task automatic check_flags();
        chk(ht_flag == vec(0), "R7", "half flags", ht_flag, vec(0));
        chk(tc_flag == vec(1), "R7", "done flags", tc_flag, vec(1));
        chk(te_flag == vec(2), "R9", "fault flags", te_flag, vec(2));
        chk(irq == (vec(0) | vec(1) | vec(2)), "R11", "irq", irq, vec(0) | vec(1) | vec(2));
    endtask

    task automatic cfg(input int c, input bit en, input int pr, input bit circ,
                       input int ss, input int ds, input logic [31:0] sa,
                       input logic [31:0] da, input int cnt);
        cfg_ch = HW'(c); cfg_en = en; cfg_prio = 2'(pr); cfg_circ = circ;
        cfg_src_size = 2'(ss); cfg_dst_size = 2'(ds);
        cfg_src_addr = sa; cfg_dst_addr = da; cfg_count = CW'(cnt);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        m_en[c] = en; m_sw[c] = 0; m_circ[c] = circ; m_prio[c] = pr;
        m_ssz[c] = ss; m_dsz[c] = ds; m_sb[c] = sa; m_db[c] = da;
        m_sc[c] = sa; m_dc[c] = da;
        m_tot[c] = (cnt % 256 == 0) ? 256 : cnt;
        m_rem[c] = m_tot[c];
    endtask

    task automatic pulse_sw(input int c);
        sw_start[c] = 1'b1;
        @(negedge clk);
        sw_start = '0;
        if (m_en[c]) m_sw[c] = 1;
    endtask

    task automatic pulse_clr(input logic [N-1:0] v);
        flag_clr = v;
        @(negedge clk);
        flag_clr = '0;
        for (int i = 0; i < N; i++)
            if (v[i]) begin m_ht[i] = 0; m_tc[i] = 0; m_te[i] = 0; end
    endtask

    // Predict the next command (after model faults) and compare.
    task automatic expect_issue(output int w, input bit hold);
        forever begin
            w = m_pick();
            if (w < 0) break;
            if (m_bad(w)) begin m_te[w] = 1; m_en[w] = 0; m_sw[w] = 0; end
            else break;
        end
        if (w < 0) begin
            repeat (N + 3) @(negedge clk);
            chk(!xfer_valid, "R4", "no command expected", xfer_valid, 0);
        end else begin
            for (int t = 0; t < 40 && !xfer_valid; t++) @(negedge clk);
            chk(xfer_valid, "R5", "command expected", xfer_valid, 1);
            chk(xfer_ch == HW'(w), "R2", "granted channel", xfer_ch, w);
            chk(xfer_src_addr == m_sc[w], "R5", "src addr", xfer_src_addr, m_sc[w]);
            chk(xfer_dst_addr == m_dc[w], "R5", "dst addr", xfer_dst_addr, m_dc[w]);
            chk(xfer_src_size == 2'(m_ssz[w]) && xfer_dst_size == 2'(m_dsz[w]),
                "R5", "sizes", {xfer_src_size, xfer_dst_size}, {2'(m_ssz[w]), 2'(m_dsz[w])});
            if (hold) begin
                @(negedge clk);
                chk(xfer_valid && xfer_ch == HW'(w) && xfer_src_addr == m_sc[w],
                    "R5", "held command", xfer_ch, w);
            end
        end
        check_flags();
    endtask

    task automatic complete(input int w, input bit err);
        xfer_ready = 1'b1; xfer_err = err;
        @(negedge clk);
        xfer_ready = 1'b0; xfer_err = 1'b0;
        if (err) begin
            m_te[w] = 1; m_en[w] = 0; m_sw[w] = 0;
        end else begin
            m_rem[w]--;
            m_sc[w] += 32'(1) << m_ssz[w];
            m_dc[w] += 32'(1) << m_dsz[w];
            if (m_rem[w] == m_tot[w] / 2) m_ht[w] = 1;
            if (m_rem[w] == 0) begin
                m_tc[w] = 1; m_sw[w] = 0;
                if (m_circ[w]) begin
                    m_rem[w] = m_tot[w]; m_sc[w] = m_sb[w]; m_dc[w] = m_db[w];
                end else m_en[w] = 0;
            end
        end
    endtask

    task automatic drain(input int limit);
        int w;
        for (int k = 0; k < limit; k++) begin
            expect_issue(w, 1'b0);
            if (w < 0) break;
            complete(w, 1'b0);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int w, cnt;
        logic [31:0] sa, da;
        void'($urandom(32'd4711));
        for (int i = 0; i < N; i++) begin
            m_en[i] = 0; m_sw[i] = 0; m_circ[i] = 0; m_ht[i] = 0; m_tc[i] = 0;
            m_te[i] = 0; m_prio[i] = 0; m_ssz[i] = 0; m_dsz[i] = 0;
            m_tot[i] = 0; m_rem[i] = 0;
            m_sb[i] = 0; m_db[i] = 0; m_sc[i] = 0; m_dc[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, requests ignored while disabled.
        chk(!xfer_valid, "R1", "valid after reset", xfer_valid, 0);
        chk(irq == '0 && te_flag == '0, "R1", "flags after reset", irq, 0);
        hw_req = '1;
        expect_issue(w, 1'b0);
        chk(w < 0, "R1", "disabled channels silent", w, -1);
        hw_req = '0;

        // R3: equal priority, lower index first.
        cfg(1, 1, 2, 0, 2, 2, 32'h100, 32'h200, 2);
        cfg(4, 1, 2, 0, 2, 2, 32'h300, 32'h400, 2);
        hw_req = 8'b0001_0010;
        expect_issue(w, 1'b1);
        chk(w == 1 && xfer_ch == 3'd1, "R3", "tie goes to ch1", xfer_ch, 1);
        complete(w, 1'b0);
        // R2: higher level beats lower index.
        hw_req = '0;
        cfg(6, 1, 3, 0, 0, 0, 32'h501, 32'h603, 1);
        hw_req = 8'b0101_0010;
        expect_issue(w, 1'b0);
        chk(w == 6 && xfer_ch == 3'd6, "R2", "very high wins", xfer_ch, 6);
        complete(w, 1'b0);
        drain(10);
        hw_req = '0;

        // R7: half then done, channel disables (byte src, half dst).
        cfg(0, 1, 1, 0, 0, 1, 32'h1001, 32'h2000, 4);
        hw_req = 8'b0000_0001;
        drain(10);
        chk(tc_flag[0] && ht_flag[0], "R7", "ch0 half+done", {ht_flag[0], tc_flag[0]}, 2'b11);
        hw_req = '0;

        // R8: circular reload of count and addresses.
        cfg(2, 1, 1, 1, 1, 2, 32'h40, 32'h80, 3);
        hw_req = 8'b0000_0100;
        for (int k = 0; k < 3; k++) begin expect_issue(w, 1'b0); complete(w, 1'b0); end
        expect_issue(w, 1'b0);
        chk(xfer_src_addr == 32'h40 && xfer_dst_addr == 32'h80, "R8", "reloaded addresses",
            xfer_src_addr, 32'h40);
        complete(w, 1'b0);
        hw_req = '0;
        cfg(2, 0, 1, 1, 1, 2, 32'h40, 32'h80, 3);

        // R9: misaligned half source and reserved size fault without a command.
        cfg(3, 1, 3, 0, 1, 0, 32'h33, 32'h0, 2);
        cfg(5, 1, 3, 0, 0, 3, 32'h10, 32'h20, 2);
        hw_req = 8'b0010_1000;
        expect_issue(w, 1'b0);
        chk(w < 0 && te_flag[3] && te_flag[5], "R9", "faults raised", te_flag, 8'h28);
        chk(irq[3] && irq[5], "R11", "fault irq", irq, 8'h28);
        hw_req = '0;

        // R10: error response faults and stops the channel.
        cfg(5, 1, 0, 0, 2, 2, 32'h700, 32'h800, 5);
        hw_req = 8'b0010_0000;
        expect_issue(w, 1'b0);
        complete(w, 1'b1);
        expect_issue(w, 1'b0);
        chk(w < 0 && te_flag[5], "R10", "error stops ch5", te_flag[5], 1);
        hw_req = '0;

        // R11: clear all flags.
        pulse_clr('1);
        chk(irq == '0 && ht_flag == '0 && tc_flag == '0 && te_flag == '0, "R11",
            "flags cleared", irq, 0);

        // R4: software start runs a block; a start on a disabled channel does nothing.
        pulse_sw(3);
        expect_issue(w, 1'b0);
        chk(w < 0, "R4", "start on disabled ch3", w, -1);
        cfg(7, 1, 0, 0, 2, 2, 32'h900, 32'hA00, 2);
        pulse_sw(7);
        drain(5);
        chk(tc_flag[7], "R4", "software block done", tc_flag[7], 1);

        // R12: higher request mid-block takes the next slot.
        cfg(1, 1, 0, 0, 0, 0, 32'h0, 32'h10, 4);
        cfg(4, 1, 3, 0, 0, 0, 32'h20, 32'h30, 1);
        hw_req = 8'b0000_0010;
        expect_issue(w, 1'b0);
        complete(w, 1'b0);
        hw_req = 8'b0001_0010;
        expect_issue(w, 1'b0);
        chk(w == 4 && xfer_ch == 3'd4, "R12", "preempting channel next", xfer_ch, 4);
        complete(w, 1'b0);
        drain(10);
        hw_req = '0;

        // R6: count zero means the full range.
        cfg(0, 1, 2, 0, 2, 2, 32'h4000, 32'h8000, 0);
        pulse_clr('1);
        hw_req = 8'b0000_0001;
        cnt = 0;
        for (int k = 0; k < 300; k++) begin
            expect_issue(w, 1'b0);
            if (w < 0) break;
            cnt++;
            complete(w, 1'b0);
        end
        chk(cnt == 256, "R6", "transfers for count 0", cnt, 256);
        chk(tc_flag[0], "R6", "done after full range", tc_flag[0], 1);
        hw_req = '0;

        // Random traffic.
        for (int c = 0; c < N; c++) begin
            sa = $urandom & 32'hFFFF_FFF0; da = $urandom & 32'hFFFF_FFF0;
            if ($urandom % 8 == 0) sa[0] = 1'b1;
            cfg(c, 1, $urandom % 4, $urandom % 2, $urandom % 3, $urandom % 3, sa, da,
                1 + $urandom % 6);
        end
        hw_req = N'($urandom);
        for (int s = 0; s < 300; s++) begin
            expect_issue(w, ($urandom % 4) == 0);
            if (w >= 0) complete(w, ($urandom % 25) == 0);
            if ($urandom % 5 == 0) begin
                hw_req = '0;
                w = $urandom % N;
                sa = $urandom & 32'hFFFF_FFF0; da = $urandom & 32'hFFFF_FFF0;
                if ($urandom % 8 == 0) da[1] = 1'b1;
                cfg(w, 1, $urandom % 4, $urandom % 2, $urandom % 3,
                    ($urandom % 10 == 0) ? 3 : $urandom % 3, sa, da, 1 + $urandom % 6);
                if ($urandom % 3 == 0) pulse_clr(N'($urandom));
            end
            hw_req = N'($urandom);
        end
        hw_req = '0;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule